// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator with Register Access

This block produces one or two pulse-width modulated outputs from a single input clock. Each channel first divides the clock by a programmable 6-bit prescaler, then steps a 10-bit period counter once per prescaled tick. The output is high at the start of each period for a programmed number of prescaled ticks and low for the rest. A separate flag holds the output high for the whole period, whatever the count holds.

Software programs each channel through three word registers on a plain register bus: control, duty and period. New settings are kept in shadow registers and copied into the running channel only when a period ends, so a period is never cut short. A per-channel enable input starts and stops each channel. A per-channel mode bit decides whether dropping the enable lets the current period finish or forces the output low on the next clock. The number of channels is a build parameter of 1 or 2.

Top module: `pwm_gen_top`

## Requirements
- R1: Channel 0 registers are at byte addresses 0x00 (control: prescale in bits 5:0, shutdown mode in bit 6), 0x04 (duty: count DC in bits 9:0, full-duty flag in bit 10) and 0x08 (period: PV in bits 9:0). Reads return the written fields, with every other bit zero.
- R2: When NUM_CH is 2, channel 1 uses the same layout at 0x10, 0x14 and 0x18. It drives `pwmOut[1]` from its own registers and its own enable, with no effect on channel 0.
- R3: While enabled, one output period lasts exactly (prescale+1)*(PV+1) input clock cycles and repeats with that length.
- R4: In each period the output is high for the first (prescale+1)*DC clock cycles and low for the rest.
- R5: With the full-duty flag set, the output stays high for the whole period, whatever DC holds.
- R6: A DC of 0 gives a constant low output. A DC greater than PV gives a constant high output.
- R7: Writes to prescale, duty or period while a channel runs do not change the current period. They take effect at the next period boundary.
- R8: With shutdown mode 0, dropping the enable lets the current period run to its end. The output then goes low and stays low.
- R9: With shutdown mode 1, dropping the enable makes the output low from the next clock onward.
- R10: Writes to unmapped addresses (0x0C, 0x1C, addresses not on a word boundary, and channel 1 addresses when NUM_CH is 1) change nothing, and reads from them return zero.
- R11: A synchronous active-high reset clears all registers and counters and drives every output low.
- R12: When the enable of a stopped channel rises, the first period begins on the next clock, with the output high from that clock if the duty is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrData | input | DATA_W | Write data |
| busWe | input | 1 | Write strobe; the write happens on the rising edge |
| busRdData | output | DATA_W | Read data for `busAddr`, combinational |
| chEn | input | NUM_CH | Run enable, one bit per channel |
| pwmOut | output | NUM_CH | Modulated output, one bit per channel |

## Verification
The hardest case to reach from the ports is a register write that lands partway through a running period. The old and new duty values must then be told apart in the output waveform. The bench starts a channel from a known enable edge, counts clocks to a chosen point after the output has fallen, and writes a longer duty there. It then checks that the rest of that period stays low and that the next period carries the new high time. Graceful shutdown is reached the same way: the enable is dropped a counted number of clocks into a period with constant-high duty. The bench checks that the output holds high up to the boundary and is low right after it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRE_W      = 6;            // prescaler width
  localparam int CNT_W      = 10;           // period/duty counter width
  localparam int REG_W      = CNT_W + 1;    // widest register field incl. full flag
  localparam int STRIDE_W   = 4;            // channel stride is 2**STRIDE_W bytes
  localparam logic [STRIDE_W-1:0] OFF_CTL  = 4'h0;
  localparam logic [STRIDE_W-1:0] OFF_DUTY = 4'h4;
  localparam logic [STRIDE_W-1:0] OFF_PER  = 4'h8;

  typedef enum logic [1:0] {REG_CTL, REG_DUTY, REG_PER, REG_NONE} pwm_reg_e;

  // write strobes from control to one channel datapath
  typedef struct packed {
    logic wrCtl;
    logic wrDuty;
    logic wrPer;
  } pwm_wr_t;

  // programmed (shadow) register contents of one channel
  typedef struct packed {
    logic             sd;
    logic [PRE_W-1:0] pre;
    logic             full;
    logic [CNT_W-1:0] dc;
    logic [CNT_W-1:0] pv;
  } pwm_regs_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5,
  localparam int CH_SEL_W = ADDR_W - STRIDE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  output pwm_wr_t [NUM_CH-1:0]  wrStb,
  output logic                  rdHit,
  output logic [CH_SEL_W-1:0]   rdCh,
  output pwm_reg_e              rdReg
);
  logic [STRIDE_W-1:0] regOff;

  always_comb begin
    rdCh   = busAddr[ADDR_W-1:STRIDE_W];
    regOff = busAddr[STRIDE_W-1:0];
    unique case (regOff)
      OFF_CTL:  rdReg = REG_CTL;
      OFF_DUTY: rdReg = REG_DUTY;
      OFF_PER:  rdReg = REG_PER;
      default:  rdReg = REG_NONE;
    endcase
    rdHit = (int'(rdCh) < NUM_CH) && (rdReg != REG_NONE);
    wrStb = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (busWe && rdHit && int'(rdCh) == i) begin
        wrStb[i].wrCtl  = (rdReg == REG_CTL);
        wrStb[i].wrDuty = (rdReg == REG_DUTY);
        wrStb[i].wrPer  = (rdReg == REG_PER);
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wrStb)); // R1
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!busWe || !rdHit) |-> (wrStb == '0)); // R10
endmodule

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             chEn,
  input  pwm_wr_t          wrStb,
  input  logic [REG_W-1:0] wBits,
  output pwm_regs_t        regs,
  output logic             pwmOut
);
  pwm_regs_t        sh;        // programmed values
  logic [PRE_W-1:0] acPre;     // values in force for the running period
  logic [CNT_W-1:0] acDc;
  logic [CNT_W-1:0] acPv;
  logic             acFull;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] perCnt;
  logic             running;
  logic             preWrap;
  logic             perWrap;

  assign regs    = sh;
  assign preWrap = (preCnt == acPre);
  assign perWrap = preWrap && (perCnt == acPv);
  assign pwmOut  = running && (acFull || (perCnt < acDc));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else begin
      if (wrStb.wrCtl) begin
        sh.pre <= wBits[PRE_W-1:0];
        sh.sd  <= wBits[PRE_W];
      end
      if (wrStb.wrDuty) begin
        sh.dc   <= wBits[CNT_W-1:0];
        sh.full <= wBits[CNT_W];
      end
      if (wrStb.wrPer) sh.pv <= wBits[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      preCnt  <= '0;
      perCnt  <= '0;
      acPre   <= '0;
      acDc    <= '0;
      acPv    <= '0;
      acFull  <= 1'b0;
    end else if (!running) begin
      if (chEn) begin
        running <= 1'b1;
        preCnt  <= '0;
        perCnt  <= '0;
        acPre   <= sh.pre;
        acDc    <= sh.dc;
        acPv    <= sh.pv;
        acFull  <= sh.full;
      end
    end else if (!chEn && sh.sd) begin
      running <= 1'b0;
    end else if (perWrap) begin
      preCnt <= '0;
      perCnt <= '0;
      if (chEn) begin
        acPre  <= sh.pre;
        acDc   <= sh.dc;
        acPv   <= sh.pv;
        acFull <= sh.full;
      end else begin
        running <= 1'b0;
      end
    end else if (preWrap) begin
      preCnt <= '0;
      perCnt <= perCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    running |-> (perCnt <= acPv) && (preCnt <= acPre)); // R3
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (running && !perWrap) |=> $stable(acDc) && $stable(acPv) && $stable(acPre) && $stable(acFull)); // R7
  AST_SD_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (running && !chEn && sh.sd) |=> !pwmOut); // R9
  AST_SD_GRACEFUL: assert property (@(posedge clk) disable iff (rst)
    (running && !chEn && !sh.sd && !perWrap) |=> running); // R8
endmodule

// File: rtl/pwm_gen_top.sv
module pwm_gen_top
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int CH_SEL_W = ADDR_W - STRIDE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWe,
  output logic [DATA_W-1:0] busRdData,
  input  logic [NUM_CH-1:0] chEn,
  output logic [NUM_CH-1:0] pwmOut
);
  pwm_wr_t [NUM_CH-1:0]  wrStb;
  pwm_regs_t             chRegs [NUM_CH];
  logic                  rdHit;
  logic [CH_SEL_W-1:0]   rdCh;
  pwm_reg_e              rdReg;
  logic                  unusedHi;

  assign unusedHi = ^busWrData[DATA_W-1:REG_W];

  pwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
    .wrStb(wrStb), .rdHit(rdHit), .rdCh(rdCh), .rdReg(rdReg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan_dp u_dp (
      .clk(clk), .rst(rst), .chEn(chEn[g]), .wrStb(wrStb[g]),
      .wBits(busWrData[REG_W-1:0]), .regs(chRegs[g]), .pwmOut(pwmOut[g])
    );
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rdHit && int'(rdCh) == i) begin
        unique case (rdReg)
          REG_CTL:  busRdData[PRE_W:0] = {chRegs[i].sd, chRegs[i].pre};
          REG_DUTY: busRdData[CNT_W:0] = {chRegs[i].full, chRegs[i].dc};
          REG_PER:  busRdData[CNT_W-1:0] = chRegs[i].pv;
          default:  busRdData = '0;
        endcase
      end
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rdHit |-> (busRdData == '0)); // R10
  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (pwmOut == '0)); // R11
endmodule

// File: tb/sim_pwm_gen_top.sv
`timescale 1ns/1ps
module sim_pwm_gen_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic [31:0] wd = '0;
  logic        we = 1'b0;
  logic [31:0] rd;
  logic [1:0]  en = '0;
  logic [1:0]  out;
  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pwm_gen_top #(.NUM_CH(2), .ADDR_W(5), .DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .busAddr(addr), .busWrData(wd), .busWe(we),
    .busRdData(rd), .chEn(en), .pwmOut(out)
  );

  // stimulus table: prescale, DC, full flag, PV, expected high clocks per period
  localparam int NV = 7;
  localparam int VPRE [NV] = '{0, 2, 0, 1, 0, 63, 0};
  localparam int VDC  [NV] = '{3, 4, 0, 0, 12, 1, 1};
  localparam int VFUL [NV] = '{0, 0, 0, 1, 0, 0, 0};
  localparam int VPV  [NV] = '{9, 7, 5, 4, 9, 1, 0};
  localparam int VHI  [NV] = '{3, 12, 0, 10, 10, 64, 1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr = a[4:0]; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdr(input int a, output int d);
    addr = a[4:0];
    #1;
    d = int'(rd);
  endtask

  task automatic stopCh(input int ch);
    wr(ch * 16, 32'h40);
    en[ch] = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int ch, input int pre, input int sd, input int dc, input int full, input int pv);
    wr(ch * 16,     (sd << 6) | pre);
    wr(ch * 16 + 4, (full << 10) | dc);
    wr(ch * 16 + 8, pv);
  endtask

  task automatic startCh(input int ch);
    en[ch] = 1'b1;
    @(negedge clk);   // now at the first clock of the first period
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int d;
    logic smp [512];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk(out == 2'b00, "R11 outputs low after reset", int'(out), 0);
    rdr(32'h04, d); chk(d == 0, "R11 duty cleared", d, 0);
    rdr(32'h18, d); chk(d == 0, "R11 ch1 period cleared", d, 0);

    // R1 field masks on read-back
    wr(32'h00, 32'hFFFFFFFF); rdr(32'h00, d); chk(d == 32'h7F, "R1 control mask", d, 32'h7F);
    wr(32'h04, 32'hFFFFFFFF); rdr(32'h04, d); chk(d == 32'h7FF, "R1 duty mask", d, 32'h7FF);
    wr(32'h08, 32'hFFFFFFFF); rdr(32'h08, d); chk(d == 32'h3FF, "R1 period mask", d, 32'h3FF);

    // R10 unmapped addresses
    wr(32'h0C, 32'hFFFFFFFF); rdr(32'h0C, d); chk(d == 0, "R10 read 0x0C", d, 0);
    wr(32'h1C, 32'hFFFFFFFF); rdr(32'h1C, d); chk(d == 0, "R10 read 0x1C", d, 0);
    wr(32'h02, 32'h0);        rdr(32'h02, d); chk(d == 0, "R10 read 0x02", d, 0);
    rdr(32'h00, d); chk(d == 32'h7F, "R10 control untouched", d, 32'h7F);
    rdr(32'h08, d); chk(d == 32'h3FF, "R10 period untouched", d, 32'h3FF);
    rdr(32'h10, d); chk(d == 0, "R10 ch1 control untouched", d, 0);

    // table of waveform vectors on channel 0
    for (int v = 0; v < NV; v++) begin
      int per, highs, firstLow, expLow, mism;
      string tag;
      stopCh(0);
      cfg(0, VPRE[v], 0, VDC[v], VFUL[v], VPV[v]);
      startCh(0);
      per = (VPRE[v] + 1) * (VPV[v] + 1);
      highs = 0; firstLow = -1; mism = 0;
      for (int i = 0; i < 2 * per; i++) begin
        smp[i] = out[0];
        if (out[0]) highs++;
        else if (firstLow < 0) firstLow = i;
        @(negedge clk);
      end
      for (int i = 0; i < per; i++) if (smp[i] != smp[i + per]) mism++;
      chk(mism == 0, "R3 period repeats", mism, 0);
      if (VFUL[v] != 0) tag = "R5";
      else if (VDC[v] == 0 || VDC[v] > VPV[v]) tag = "R6";
      else tag = "R4";
      chk(highs == 2 * VHI[v], {tag, " high clocks over two periods"}, highs, 2 * VHI[v]);
      expLow = (VHI[v] < per) ? VHI[v] : -1;
      chk(firstLow == expLow, {tag, " falling position"}, firstLow, expLow);
      chk(smp[0] == (VHI[v] > 0), "R12 high on first clock after enable", int'(smp[0]), int'(VHI[v] > 0));
    end

    // R7 mid-period duty write takes effect at the next boundary
    begin
      int highs;
      stopCh(0);
      cfg(0, 0, 0, 2, 0, 9);
      startCh(0);                      // index 0
      repeat (3) @(negedge clk);       // index 3, output already low
      wr(32'h04, 5);                   // written at end of index 3, now index 4
      highs = 0;
      for (int i = 4; i < 10; i++) begin if (out[0]) highs++; @(negedge clk); end
      chk(highs == 0, "R7 current period keeps old duty", highs, 0);
      highs = 0;
      for (int i = 10; i < 20; i++) begin if (out[0]) highs++; @(negedge clk); end
      chk(highs == 5, "R7 next period uses new duty", highs, 5);
    end

    // R8 graceful stop
    begin
      int highs;
      stopCh(0);
      cfg(0, 0, 0, 12, 0, 9);
      startCh(0);
      repeat (3) @(negedge clk);       // index 3
      en[0] = 1'b0;
      highs = 0;
      for (int i = 3; i < 10; i++) begin if (out[0]) highs++; @(negedge clk); end
      chk(highs == 7, "R8 period finishes after enable drop", highs, 7);
      highs = 0;
      for (int i = 10; i < 20; i++) begin if (out[0]) highs++; @(negedge clk); end
      chk(highs == 0, "R8 low after boundary", highs, 0);
    end

    // R9 immediate stop
    stopCh(0);
    cfg(0, 0, 1, 12, 0, 9);
    startCh(0);
    repeat (3) @(negedge clk);
    chk(out[0] == 1'b1, "R9 high before drop", int'(out[0]), 1);
    en[0] = 1'b0;
    @(negedge clk);
    chk(out[0] == 1'b0, "R9 low on next clock", int'(out[0]), 0);

    // R2 second channel
    begin
      int h1, h0;
      stopCh(0);
      cfg(1, 0, 0, 1, 0, 3);
      rdr(32'h14, d); chk(d == 1, "R2 ch1 duty read-back", d, 1);
      rdr(32'h04, d); chk(d == 12, "R2 ch0 duty unaffected", d, 12);
      startCh(1);
      h1 = 0; h0 = 0;
      for (int i = 0; i < 8; i++) begin
        if (out[1]) h1++;
        if (out[0]) h0++;
        @(negedge clk);
      end
      chk(h1 == 2, "R2 ch1 high clocks", h1, 2);
      chk(h0 == 0, "R2 ch0 stays low", h0, 0);
    end

    // R11 reset while running
    stopCh(0);
    cfg(0, 0, 0, 12, 0, 9);
    startCh(0);
    rst = 1'b1;
    @(negedge clk);
    chk(out == 2'b00, "R11 reset drives outputs low", int'(out), 0);
    rdr(32'h04, d); chk(d == 0, "R11 reset clears duty", d, 0);
    rst = 1'b0;
    en = '0;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule